// File: doc/BRIEF.md
# Interrupt Presenter Thread Context Matcher

This block takes one event notification at a time and works out which hardware thread, and which privilege ring on that thread, currently holds the notification's target. A target is given by a block number, an index, a format bit, an ignore bit and a logical server number. Each of a fixed number of threads keeps one context word for each of four rings (user, OS, pool, physical). Those words are loaded through a simple write port. Each thread also has a fixed processor ID.

After a valid/ready handshake, the matcher visits one thread per clock and applies ring-specific compare rules. It keeps the first hit and keeps going to the last thread so that a second hit can be caught. The search ends with a one-cycle done pulse that carries exactly one outcome: found (with thread and ring), duplicate, not dispatched, or unsupported. A system-level presenter uses the result to pick the thread that receives the interrupt.

Context word layout (every ring): bit 31 is the valid bit. Bits 22:0 hold the target CAM for the pool and OS rings. Bits 7:0 hold the logical server number for the user ring. Only bit 31 matters for the physical ring.

Top module: `irq_thread_matcher`

## Requirements
- R1: The pool ring of a thread matches when its word has bit 31 set and its bits 22:0 equal the software CAM, which is the block shifted left by 19 ORed with the 19-bit index.
- R2: The OS ring matches by the same rule as R1, using the OS word.
- R3: The physical ring matches when its word has bit 31 set and the thread's hardwired 23-bit CAM equals the one built from the request. In normal layout the CAM holds chip at bits 14:11, a 1 at bit 7 and thread at bits 6:0. Chip is processor ID bits 11:8 and thread is processor ID bits 6:0. For the request, the block is used as chip and index bits 6:0 as thread. No other processor ID or index bit has an effect.
- R4: With the block-group mode input high at acceptance, both CAMs use the layout with a 1 at bit 11, chip at bits 10:7 and thread at bits 6:0. The outcome therefore still depends only on chip and thread equality.
- R5: The user ring matches only when all of these hold: the OS word is valid, the OS word's CAM matches, the user word is valid, and user bits 7:0 equal the requested logical server.
- R6: For format 0, rings are tried in the order physical, pool, OS, and the first hit is reported. The ring code is 3 for physical, 2 for pool, 1 for OS and 0 for user. The user ring is never reported for format 0.
- R7: For format 1, only the user ring is tried, whatever the ignore bit is.
- R8: Format 0 with the ignore bit set gives done with unsupported and no match, one cycle after acceptance.
- R9: If a second thread matches, the search stops at that thread with done and duplicate set. Done comes j+2 cycles after acceptance, where j is the second matching thread.
- R10: A completed search reports found with the lowest matching thread, or not dispatched when no thread matched. Done comes NUM_THREADS+1 cycles after acceptance.
- R11: Ready is low while a search is running and during the done cycle. Done lasts one cycle, and exactly one outcome flag is set with it.
- R12: Synchronous reset clears every context word, so no ring matches until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Context word write strobe |
| wr_thread | input | TID_W | Thread of the written word |
| wr_ring | input | 2 | Ring of the written word (ring code) |
| wr_data | input | CTX_W | Context word value |
| hw_pir | input | NUM_THREADS*PIR_W | Fixed processor ID of each thread, thread 0 lowest |
| blkgrp_mode | input | 1 | Selects the block-group physical CAM layout |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_format | input | 1 | Notification format |
| req_ignore | input | 1 | Ignore flag (logical-server notification) |
| req_block | input | BLK_W | Target block |
| req_index | input | IDX_W | Target index |
| req_lserv | input | LSRV_W | Requested logical server number |
| done | output | 1 | One-cycle result pulse |
| found | output | 1 | A unique match was found |
| match_thread | output | TID_W | Matching thread |
| match_ring | output | 2 | Matching ring code |
| dup_err | output | 1 | More than one thread matched |
| not_dispatched | output | 1 | No thread matched |
| unsupported | output | 1 | Logical-server notification refused |

## Verification
The bench sweeps every thread against every target for the physical ring under both CAM layouts, with junk in the ignored index and processor ID bits. A design that used the wrong layout on one side, or compared extra bits, would miss or falsely hit. It builds stacks of pool, OS and physical hits on one thread and removes them one at a time. It also switches off each condition of the user rule in turn, so a wrong priority order or a missing condition shows up as the wrong ring or as a false hit. Every pair of duplicate threads is tried, and the done latency is checked, so a design that stopped at the first hit or did not abort on the second would report found or finish on the wrong cycle. The unsupported case, the done latency and reset during live contexts are also checked.

// File: rtl/itm_pkg.sv
package itm_pkg;

   typedef enum logic [1:0] {
      RING_USER = 2'd0,
      RING_OS   = 2'd1,
      RING_POOL = 2'd2,
      RING_PHYS = 2'd3
   } ring_e;

   localparam int HWCAM_W = 23;

   // Hardwired physical CAM, two layouts
   function automatic logic [HWCAM_W-1:0] hw_cam(input logic grp,
                                                 input logic [3:0] chip,
                                                 input logic [6:0] tid);
      logic [HWCAM_W-1:0] c;
      c = '0;
      c[6:0] = tid;
      if (grp) begin
         c[11]   = 1'b1;
         c[10:7] = chip;
      end else begin
         c[14:11] = chip;
         c[7]     = 1'b1;
      end
      return c;
   endfunction

endpackage

// File: rtl/itm_ctx_regs.sv
module itm_ctx_regs #(
   parameter int NT    = 4,
   parameter int CTX_W = 32,
   parameter int TID_W = 2
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr_en,
   input  logic [TID_W-1:0]              wr_thread,
   input  logic [1:0]                    wr_ring,
   input  logic [CTX_W-1:0]              wr_data,
   output logic [NT-1:0][3:0][CTX_W-1:0] ctx_q
);
   localparam int VBIT = CTX_W - 1;

   for (genvar t = 0; t < NT; t++) begin : g_thr
      logic [3:0][CTX_W-1:0] words;

      always_ff @(posedge clk) begin
         if (rst) begin
            words <= '0;
         end else if (wr_en && wr_thread == TID_W'(t)) begin
            words[wr_ring] <= wr_data;
         end
      end

      assign ctx_q[t] = words;

      for (genvar r = 0; r < 4; r++) begin : g_ring
         // R12: no valid context survives reset
         p_reset_clears_r12: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !words[r][VBIT]);
      end
   end

endmodule

// File: rtl/itm_ring_match.sv
module itm_ring_match
   import itm_pkg::*;
#(
   parameter int CTX_W  = 32,
   parameter int BLK_W  = 4,
   parameter int IDX_W  = 19,
   parameter int LSRV_W = 8,
   parameter int PIR_W  = 16,
   parameter bit GRP_EN = 1'b1
) (
   input  logic [CTX_W-1:0]  w_phys,
   input  logic [CTX_W-1:0]  w_pool,
   input  logic [CTX_W-1:0]  w_os,
   input  logic [CTX_W-1:0]  w_user,
   input  logic [PIR_W-1:0]  pir,
   input  logic              fmt,
   input  logic              grp,
   input  logic [BLK_W-1:0]  blk,
   input  logic [IDX_W-1:0]  idx,
   input  logic [LSRV_W-1:0] lserv,
   output logic              hit,
   output ring_e             hit_ring
);
   localparam int CAM_W = BLK_W + IDX_W;
   localparam int VBIT  = CTX_W - 1;

   logic              use_grp;
   logic [CAM_W-1:0]  soft_cam;
   logic [HWCAM_W-1:0] thr_cam, req_cam;
   logic              phys_hit, pool_hit, os_hit, user_hit;

   if (GRP_EN) begin : g_grp
      assign use_grp = grp;
   end else begin : g_fixed
      assign use_grp = 1'b0;
   end

   assign soft_cam = {blk, idx};
   assign thr_cam  = hw_cam(use_grp, pir[11:8], pir[6:0]);
   assign req_cam  = hw_cam(use_grp, blk[3:0], idx[6:0]);

   assign phys_hit = w_phys[VBIT] && (thr_cam == req_cam);
   assign pool_hit = w_pool[VBIT] && (w_pool[CAM_W-1:0] == soft_cam);
   assign os_hit   = w_os[VBIT]   && (w_os[CAM_W-1:0]   == soft_cam);
   assign user_hit = os_hit && w_user[VBIT] && (w_user[LSRV_W-1:0] == lserv);

   always_comb begin
      hit      = 1'b0;
      hit_ring = RING_USER;
      if (fmt) begin
         hit      = user_hit;
         hit_ring = RING_USER;
      end else if (phys_hit) begin
         hit      = 1'b1;
         hit_ring = RING_PHYS;
      end else if (pool_hit) begin
         hit      = 1'b1;
         hit_ring = RING_POOL;
      end else if (os_hit) begin
         hit      = 1'b1;
         hit_ring = RING_OS;
      end
   end

   logic unused_bits;
   assign unused_bits = ^{w_phys[VBIT-1:0], w_pool[VBIT-1:CAM_W], w_os[VBIT-1:CAM_W],
                          w_user[VBIT-1:LSRV_W], pir[PIR_W-1:12], pir[7], grp};

endmodule

// File: rtl/itm_scan_ctrl.sv
module itm_scan_ctrl
   import itm_pkg::*;
#(
   parameter int NT    = 4,
   parameter int TID_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic             req_unsup,
   output logic             req_ready,
   output logic             accept,
   output logic             busy,
   output logic [TID_W-1:0] scan_sel,
   input  logic             hit,
   input  ring_e            hit_ring,
   output logic             done,
   output logic             found,
   output logic             dup_err,
   output logic             not_disp,
   output logic             unsup,
   output logic [TID_W-1:0] res_thread,
   output ring_e            res_ring
);
   localparam logic [TID_W-1:0] LAST = TID_W'(NT - 1);

   typedef enum logic {S_IDLE, S_SCAN} st_e;
   st_e        st;
   logic [TID_W-1:0] cnt;
   logic       have;

   assign req_ready = (st == S_IDLE) && !done;
   assign accept    = req_valid && req_ready;
   assign busy      = (st == S_SCAN);
   assign scan_sel  = cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= S_IDLE;
         cnt        <= '0;
         have       <= 1'b0;
         done       <= 1'b0;
         found      <= 1'b0;
         dup_err    <= 1'b0;
         not_disp   <= 1'b0;
         unsup      <= 1'b0;
         res_thread <= '0;
         res_ring   <= RING_USER;
      end else begin
         done     <= 1'b0;
         found    <= 1'b0;
         dup_err  <= 1'b0;
         not_disp <= 1'b0;
         unsup    <= 1'b0;
         case (st)
            S_IDLE: begin
               if (accept) begin
                  if (req_unsup) begin
                     done  <= 1'b1;
                     unsup <= 1'b1;
                  end else begin
                     st   <= S_SCAN;
                     cnt  <= '0;
                     have <= 1'b0;
                  end
               end
            end
            S_SCAN: begin
               if (hit && have) begin
                  done    <= 1'b1;
                  dup_err <= 1'b1;
                  st      <= S_IDLE;
               end else begin
                  if (hit) begin
                     have       <= 1'b1;
                     res_thread <= cnt;
                     res_ring   <= hit_ring;
                  end
                  if (cnt == LAST) begin
                     done     <= 1'b1;
                     found    <= have || hit;
                     not_disp <= !(have || hit);
                     st       <= S_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R11: done is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R11: an accepted request takes ready down on the next cycle
   p_accept_drops_ready_r11: assert property (@(posedge clk) disable iff (rst)
      accept |=> !req_ready);
   // R11/R9/R10: exactly one outcome with done
   p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
      done |-> $onehot({found, dup_err, not_disp, unsup}));
   // R8: refused request answers on the next cycle
   p_unsup_next_r8: assert property (@(posedge clk) disable iff (rst)
      (accept && req_unsup) |=> (done && unsup && !found));

endmodule

// File: rtl/irq_thread_matcher.sv
module irq_thread_matcher
   import itm_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int CTX_W       = 32,
   parameter int BLK_W       = 4,
   parameter int IDX_W       = 19,
   parameter int LSRV_W      = 8,
   parameter int PIR_W       = 16,
   parameter bit GRP_EN      = 1'b1,
   localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         wr_en,
   input  logic [TID_W-1:0]             wr_thread,
   input  logic [1:0]                   wr_ring,
   input  logic [CTX_W-1:0]             wr_data,
   input  logic [NUM_THREADS*PIR_W-1:0] hw_pir,
   input  logic                         blkgrp_mode,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic                         req_format,
   input  logic                         req_ignore,
   input  logic [BLK_W-1:0]             req_block,
   input  logic [IDX_W-1:0]             req_index,
   input  logic [LSRV_W-1:0]            req_lserv,
   output logic                         done,
   output logic                         found,
   output logic [TID_W-1:0]             match_thread,
   output logic [1:0]                   match_ring,
   output logic                         dup_err,
   output logic                         not_dispatched,
   output logic                         unsupported
);
   localparam int CAM_W = BLK_W + IDX_W;
   localparam int VBIT  = CTX_W - 1;

   if (NUM_THREADS < 2)      begin : g_chk_nt  $error("NUM_THREADS must be at least 2"); end
   if (CAM_W > CTX_W - 1)    begin : g_chk_cam $error("CAM does not fit below valid bit"); end
   if (LSRV_W > CTX_W - 1)   begin : g_chk_ls  $error("server field too wide"); end
   if (BLK_W < 4 || IDX_W < 7) begin : g_chk_hw $error("block/index too narrow for physical CAM"); end
   if (PIR_W < 13)           begin : g_chk_pir $error("PIR_W must exceed 12"); end

   logic [NUM_THREADS-1:0][3:0][CTX_W-1:0] ctx_q;
   logic [PIR_W-1:0] pir_arr [NUM_THREADS];

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_pir
      assign pir_arr[t] = hw_pir[t*PIR_W +: PIR_W];
   end

   itm_ctx_regs #(.NT(NUM_THREADS), .CTX_W(CTX_W), .TID_W(TID_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_thread(wr_thread),
      .wr_ring(wr_ring), .wr_data(wr_data), .ctx_q(ctx_q));

   // Request latched at acceptance
   logic              fmt_q, grp_q;
   logic [BLK_W-1:0]  blk_q;
   logic [IDX_W-1:0]  idx_q;
   logic [LSRV_W-1:0] ls_q;
   logic              accept, busy, hit;
   logic [TID_W-1:0]  scan_sel;
   ring_e             hit_ring, res_ring;

   always_ff @(posedge clk) begin
      if (rst) begin
         fmt_q <= 1'b0;
         grp_q <= 1'b0;
         blk_q <= '0;
         idx_q <= '0;
         ls_q  <= '0;
      end else if (accept) begin
         fmt_q <= req_format;
         grp_q <= blkgrp_mode;
         blk_q <= req_block;
         idx_q <= req_index;
         ls_q  <= req_lserv;
      end
   end

   logic [CTX_W-1:0] sel_phys, sel_pool, sel_os, sel_user;
   assign sel_phys = ctx_q[scan_sel][RING_PHYS];
   assign sel_pool = ctx_q[scan_sel][RING_POOL];
   assign sel_os   = ctx_q[scan_sel][RING_OS];
   assign sel_user = ctx_q[scan_sel][RING_USER];

   itm_ring_match #(.CTX_W(CTX_W), .BLK_W(BLK_W), .IDX_W(IDX_W), .LSRV_W(LSRV_W),
                    .PIR_W(PIR_W), .GRP_EN(GRP_EN)) u_match (
      .w_phys(sel_phys), .w_pool(sel_pool), .w_os(sel_os), .w_user(sel_user),
      .pir(pir_arr[scan_sel]), .fmt(fmt_q), .grp(grp_q), .blk(blk_q), .idx(idx_q),
      .lserv(ls_q), .hit(hit), .hit_ring(hit_ring));

   itm_scan_ctrl #(.NT(NUM_THREADS), .TID_W(TID_W)) u_ctrl (
      .clk(clk), .rst(rst), .req_valid(req_valid),
      .req_unsup(!req_format && req_ignore), .req_ready(req_ready),
      .accept(accept), .busy(busy), .scan_sel(scan_sel), .hit(hit && busy),
      .hit_ring(hit_ring), .done(done), .found(found), .dup_err(dup_err),
      .not_disp(not_dispatched), .unsup(unsupported), .res_thread(match_thread),
      .res_ring(res_ring));

   assign match_ring = res_ring;

   // R7: format 1 can only land on the user ring
   p_fmt1_user_only_r7: assert property (@(posedge clk) disable iff (rst)
      (done && found && fmt_q) |-> (match_ring == RING_USER));
   // R6: format 0 never reports the user ring
   p_fmt0_no_user_r6: assert property (@(posedge clk) disable iff (rst)
      (done && found && !fmt_q) |-> (match_ring != RING_USER));
   // R5: a user-ring hit needs both the OS and user words valid
   p_user_needs_os_r5: assert property (@(posedge clk) disable iff (rst)
      (busy && hit && hit_ring == RING_USER) |-> (sel_os[VBIT] && sel_user[VBIT]));

endmodule

// File: tb/tb_irq_thread_matcher.sv
module tb_irq_thread_matcher;
   localparam int NT = 4;
   localparam int LAT_FULL = NT + 1;
   localparam int K_FOUND = 0, K_DUP = 1, K_ND = 2, K_UNS = 3;
   localparam logic [1:0] RU = 2'd0, RO = 2'd1, RP = 2'd2, RH = 2'd3;
   localparam logic [31:0] VBIT = 32'h8000_0000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic wr_en = 0; logic [1:0] wr_thread = 0; logic [1:0] wr_ring = 0;
   logic [31:0] wr_data = 0;
   logic [NT*16-1:0] hw_pir;
   logic blkgrp_mode = 0, req_valid = 0, req_format = 0, req_ignore = 0;
   logic [3:0] req_block = 0; logic [18:0] req_index = 0; logic [7:0] req_lserv = 0;
   logic req_ready, done, found, dup_err, not_dispatched, unsupported;
   logic [1:0] match_thread, match_ring;

   irq_thread_matcher dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_thread(wr_thread), .wr_ring(wr_ring),
      .wr_data(wr_data), .hw_pir(hw_pir), .blkgrp_mode(blkgrp_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_format(req_format),
      .req_ignore(req_ignore), .req_block(req_block), .req_index(req_index),
      .req_lserv(req_lserv), .done(done), .found(found), .match_thread(match_thread),
      .match_ring(match_ring), .dup_err(dup_err), .not_dispatched(not_dispatched),
      .unsupported(unsupported));

   int checks = 0, errors = 0;

   function automatic logic [3:0] chip_of(input int t); return 4'(t + 3); endfunction
   function automatic logic [6:0] tid_of(input int t);  return 7'(32 + 5 * t); endfunction
   function automatic logic [31:0] camw(input logic [3:0] b, input logic [18:0] i);
      return {1'b1, 8'h00, b, i};
   endfunction
   function automatic logic [31:0] userw(input logic [7:0] ls);
      return {1'b1, 23'h0, ls};
   endfunction

   // Processor IDs: junk in bits 15:12 and bit 7 must not matter (R3)
   always_comb
      for (int t = 0; t < NT; t++)
         hw_pir[t*16 +: 16] = {4'hA, chip_of(t), 1'b1, tid_of(t)};

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", what, act, exp);
      end
   endtask

   task automatic wr(input int t, input logic [1:0] r, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; wr_thread = 2'(t); wr_ring = r; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic clear_all();
      for (int t = 0; t < NT; t++)
         for (int r = 0; r < 4; r++) wr(t, 2'(r), 32'h0);
   endtask

   logic r_found, r_dup, r_nd, r_uns; logic [1:0] r_thr, r_ring; int r_lat;

   task automatic run(input logic f, input logic ig, input logic [3:0] b,
                      input logic [18:0] i, input logic [7:0] ls, input logic g);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_format = f; req_ignore = ig; req_block = b; req_index = i;
      req_lserv = ls; blkgrp_mode = g; req_valid = 1;
      @(posedge clk);
      r_lat = 0;
      forever begin
         @(negedge clk);
         req_valid = 0;
         blkgrp_mode = ~g; // mode is only looked at on acceptance
         r_lat++;
         if (done) begin
            r_found = found; r_dup = dup_err; r_nd = not_dispatched; r_uns = unsupported;
            r_thr = match_thread; r_ring = match_ring;
            chk(!req_ready, "R11 ready low during done", int'(req_ready), 0);
            break;
         end
         chk(!req_ready, "R11 ready low while scanning", int'(req_ready), 0);
         if (r_lat > 40) begin
            chk(1'b0, "R11 done never came", r_lat, 0);
            r_found = 0; r_dup = 0; r_nd = 0; r_uns = 0;
            break;
         end
      end
      @(negedge clk);
      chk(!done, "R11 done single cycle", int'(done), 0);
   endtask

   task automatic expect_res(input int kind, input int thr, input int ring,
                             input int lat, input string tag);
      logic [3:0] got, exp;
      got = {r_found, r_dup, r_nd, r_uns};
      exp = 4'b1000 >> kind;
      chk(got == exp, {tag, " outcome {found,dup,nd,uns}"}, int'(got), int'(exp));
      if (kind == K_FOUND) begin
         chk(int'(r_thr) == thr, {tag, " thread"}, int'(r_thr), thr);
         chk(int'(r_ring) == ring, {tag, " ring"}, int'(r_ring), ring);
      end
      chk(r_lat == lat, {tag, " latency"}, r_lat, lat);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R12 / R11: reset state
      chk(req_ready == 1'b1, "R11 ready after reset", int'(req_ready), 1);
      chk(done == 1'b0, "R12 no done after reset", int'(done), 0);
      run(0, 0, chip_of(0), {12'h0, tid_of(0)}, 8'h0, 0);
      expect_res(K_ND, 0, 0, LAT_FULL, "R12 empty after reset");
      run(1, 0, 4'h0, 19'h0, 8'h0, 0);
      expect_res(K_ND, 0, 0, LAT_FULL, "R12 user with zero fields");

      // R3/R4: physical ring sweep, both layouts, every thread vs every target
      for (int g = 0; g < 2; g++)
         for (int t = 0; t < NT; t++) begin
            clear_all();
            wr(t, RH, VBIT);
            for (int u = 0; u < NT; u++) begin
               run(0, 0, chip_of(u), {12'hABC, tid_of(u)}, 8'h0, 1'(g));
               if (u == t) expect_res(K_FOUND, t, 3, LAT_FULL, g ? "R4 phys group hit" : "R3 phys hit");
               else        expect_res(K_ND, 0, 0, LAT_FULL, g ? "R4 phys group miss" : "R3 phys miss");
            end
            // right thread number, wrong chip
            run(0, 0, chip_of(t) ^ 4'h8, {12'h0, tid_of(t)}, 8'h0, 1'(g));
            expect_res(K_ND, 0, 0, LAT_FULL, "R3 phys chip mismatch");
         end
      clear_all();
      wr(1, RH, 32'h7FFF_FFFF);
      run(0, 0, chip_of(1), {12'h0, tid_of(1)}, 8'h0, 0);
      expect_res(K_ND, 0, 0, LAT_FULL, "R3 phys invalid");

      // R1/R2: pool and OS rings on each thread
      for (int t = 0; t < NT; t++) begin
         logic [3:0] b; logic [18:0] i;
         b = 4'(9 + t); i = 19'(20'h3_1234 + 20'(t * 977));
         clear_all();
         wr(t, RP, camw(b, i));
         run(0, 0, b, i, 8'h0, 0);
         expect_res(K_FOUND, t, 2, LAT_FULL, "R1 pool hit");
         run(0, 0, b, i ^ 19'h4_0000, 8'h0, 0);
         expect_res(K_ND, 0, 0, LAT_FULL, "R1 pool index high bit mismatch");
         run(0, 0, b ^ 4'h1, i, 8'h0, 0);
         expect_res(K_ND, 0, 0, LAT_FULL, "R1 pool block mismatch");
         clear_all();
         wr(t, RO, camw(b, i));
         run(0, 0, b, i, 8'h0, 0);
         expect_res(K_FOUND, t, 1, LAT_FULL, "R2 os hit");
         wr(t, RO, camw(b, i) & ~VBIT);
         run(0, 0, b, i, 8'h0, 0);
         expect_res(K_ND, 0, 0, LAT_FULL, "R2 os invalid");
      end

      // R6: priority on thread 2, peeled one ring at a time
      begin
         logic [3:0] b; logic [18:0] i;
         b = chip_of(2); i = {12'h0, tid_of(2)};
         clear_all();
         wr(2, RH, VBIT); wr(2, RP, camw(b, i)); wr(2, RO, camw(b, i));
         run(0, 0, b, i, 8'h0, 0);
         expect_res(K_FOUND, 2, 3, LAT_FULL, "R6 phys over pool and os");
         wr(2, RH, 32'h0);
         run(0, 0, b, i, 8'h0, 0);
         expect_res(K_FOUND, 2, 2, LAT_FULL, "R6 pool over os");
         wr(2, RP, 32'h0);
         run(0, 0, b, i, 8'h0, 0);
         expect_res(K_FOUND, 2, 1, LAT_FULL, "R6 os last");
         wr(2, RU, userw(8'h5A));
         run(0, 0, b, i, 8'h5A, 0);
         expect_res(K_FOUND, 2, 1, LAT_FULL, "R6 format0 skips user");
      end

      // R5/R7: user ring on thread 1
      begin
         logic [3:0] b; logic [18:0] i;
         b = 4'hE; i = 19'h6_0F0F;
         clear_all();
         wr(1, RO, camw(b, i)); wr(1, RU, userw(8'hC3));
         run(1, 0, b, i, 8'hC3, 0);
         expect_res(K_FOUND, 1, 0, LAT_FULL, "R5 user hit");
         run(1, 1, b, i, 8'hC3, 0);
         expect_res(K_FOUND, 1, 0, LAT_FULL, "R7 format1 ignores ignore bit");
         run(1, 0, b, i, 8'hC2, 0);
         expect_res(K_ND, 0, 0, LAT_FULL, "R5 server mismatch");
         run(1, 0, b, i ^ 19'h1, 8'hC3, 0);
         expect_res(K_ND, 0, 0, LAT_FULL, "R5 os cam mismatch");
         wr(1, RU, userw(8'hC3) & ~VBIT);
         run(1, 0, b, i, 8'hC3, 0);
         expect_res(K_ND, 0, 0, LAT_FULL, "R5 user invalid");
         wr(1, RU, userw(8'hC3));
         wr(1, RO, camw(b, i) & ~VBIT);
         run(1, 0, b, i, 8'hC3, 0);
         expect_res(K_ND, 0, 0, LAT_FULL, "R5 os invalid");
         clear_all();
         wr(3, RP, camw(b, i)); wr(3, RH, VBIT); wr(3, RU, userw(8'hC3));
         run(1, 0, b, i, 8'hC3, 0);
         expect_res(K_ND, 0, 0, LAT_FULL, "R7 format1 ignores pool and phys");
      end

      // R8: logical-server notification refused even with a live match
      clear_all();
      wr(0, RP, camw(4'h2, 19'h11));
      run(0, 1, 4'h2, 19'h11, 8'h0, 0);
      expect_res(K_UNS, 0, 0, 1, "R8 unsupported");
      run(0, 0, 4'h2, 19'h11, 8'h0, 0);
      expect_res(K_FOUND, 0, 2, LAT_FULL, "R8 next request still served");

      // R9: every duplicate pair, abort at the second thread
      for (int j = 0; j < NT; j++)
         for (int k = j + 1; k < NT; k++) begin
            clear_all();
            wr(j, RP, camw(4'h7, 19'h2_2222));
            wr(k, RO, camw(4'h7, 19'h2_2222));
            run(0, 0, 4'h7, 19'h2_2222, 8'h0, 0);
            expect_res(K_DUP, 0, 0, k + 2, "R9 duplicate pair");
         end
      clear_all();
      wr(0, RP, camw(4'h7, 19'h5)); wr(1, RP, camw(4'h7, 19'h5)); wr(3, RP, camw(4'h7, 19'h5));
      run(0, 0, 4'h7, 19'h5, 8'h0, 0);
      expect_res(K_DUP, 0, 0, 3, "R9 triple aborts at thread 1");

      // R10: lowest matching thread on last slot; not dispatched
      clear_all();
      wr(3, RO, camw(4'h1, 19'h7));
      run(0, 0, 4'h1, 19'h7, 8'h0, 0);
      expect_res(K_FOUND, 3, 1, LAT_FULL, "R10 match on last thread");
      run(0, 0, 4'h1, 19'h8, 8'h0, 0);
      expect_res(K_ND, 0, 0, LAT_FULL, "R10 not dispatched");

      // R12: reset wipes live contexts
      @(negedge clk); rst = 1;
      @(negedge clk); @(negedge clk); rst = 0;
      run(0, 0, 4'h1, 19'h7, 8'h0, 0);
      expect_res(K_ND, 0, 0, LAT_FULL, "R12 reset clears context");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule